// File: doc/BRIEF.md
# Segmented Pattern Playback Sequencer

This block steps a read address through a user pattern memory to play a test sequence made of up to four segments. Every segment is described by a base word address and a length, both in units of one 512-bit memory word, so segment boundaries fall on 512-bit chunks. The segments play in table order, one memory word per clock. A single loop may cover a contiguous group of segments and repeats a programmed number of passes or forever. When the loop is done, playback goes on with the segment after the group.

A run begins on a one-cycle software command or on a rising edge at an asynchronous auxiliary input. The auxiliary input passes through a two-flop synchroniser and an edge detector, so a level that stays high cannot start a second run. The block checks the segment table and loop settings at all times. While they are inconsistent it raises an error flag and refuses to start. The outputs give the memory read address with a valid flag, the current segment index, the loop passes remaining and a done flag. The pattern memory and the serialiser sit outside the block. The table must stay stable while a run is in progress.

Top module: `pps_player`

## Requirements
- R1: During a run, `rd_addr` steps through each segment from its base word to base+length−1, one word per clock, with segments in table order 0, 1, 2, … up to `seg_count`−1, and `seg_idx` gives the segment of the word on `rd_addr`. Segment i takes its base from `seg_base[i*ADDR_W +: ADDR_W]` and its length from `seg_len[i*LEN_W +: LEN_W]`.
- R2: When `cmd_start` is sampled high at a clock edge with `en` high, the block idle and `cfg_err` low, `rd_valid` is high after that edge, with `rd_addr` set to segment 0's base and `seg_idx` set to 0.
- R3: A rising edge on `aux_in` starts a run under the same conditions as R2. `rd_valid` first rises after the third rising clock edge that follows `aux_in` going high. A level that stays high does not start another run.
- R4: With `loop_on` set and `loop_reps` = N ≥ 1, the segments `loop_first`..`loop_last` play N times in total, and then playback goes on with segment `loop_last`+1. `loops_left` equals N from the start of the run through the first pass. It drops by one at each jump back and reads 0 after the loop exits.
- R5: With `loop_on` set and `loop_reps` = 0, the loop group repeats without end, the run never completes, and `loops_left` reads 0.
- R6: The cycle after the last word of the final segment (when no jump back follows), `rd_valid` is low and `done` is high. `rd_addr` holds that last word, and `done` stays high until the next accepted start or until `en` goes low.
- R7: `cfg_err` is high, combinationally, if `seg_count` is 0 or more than NSEG, if any segment below `seg_count` has length 0, or if `loop_on` is set with `loop_first` > `loop_last` or `loop_last` ≥ `seg_count`. While `cfg_err` is high, no start is accepted.
- R8: A command or an aux edge that arrives while a run is in progress has no effect on the address sequence.
- R9: With `en` low, the block is idle: `rd_valid` and `done` are low after the next clock edge, and no start is accepted.
- R10: After reset, `rd_valid`, `done`, `seg_idx`, `loops_left` and `rd_addr` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Word clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Block enable; low forces idle |
| cmd_start | input | 1 | Software start pulse |
| aux_in | input | 1 | Asynchronous auxiliary start input (rising edge) |
| seg_base | input | NSEG*ADDR_W | Base word address for each segment |
| seg_len | input | NSEG*LEN_W | Length in 512-bit words for each segment |
| seg_count | input | $clog2(NSEG+1) | Number of segments used |
| loop_on | input | 1 | Loop enable |
| loop_first | input | $clog2(NSEG) | First segment of the loop group |
| loop_last | input | $clog2(NSEG) | Last segment of the loop group |
| loop_reps | input | CNT_W | Total loop passes; 0 means endless |
| rd_addr | output | ADDR_W | Pattern memory word address |
| rd_valid | output | 1 | A run is in progress; `rd_addr` is live |
| seg_idx | output | $clog2(NSEG) | Segment of the current word |
| loops_left | output | CNT_W | Loop passes remaining, including the current one |
| done | output | 1 | The run finished; address held |
| cfg_err | output | 1 | Segment or loop settings are inconsistent |

## Verification
The hardest case to reach is the transition at the end of a loop group. Here the block must choose between a jump back, an exit to the following segment and completion of the whole run, and it must update the pass counter in that same cycle. The bench reaches it through tables in which a one-word segment closes the loop group and a further segment follows the group. A software command is pulsed in the middle of those passes, and the full address, segment and pass-count trace is compared word by word against a model built from the requirements. A second case is hard to reach because of the synchroniser: an aux level is held high across a whole run and past its end, to show that a level is not taken as a fresh edge.

// File: rtl/pps_pkg.sv
package pps_pkg;
   typedef enum logic [1:0] {
      ACT_NEXT   = 2'd0,
      ACT_LOOP   = 2'd1,
      ACT_FINISH = 2'd2
   } seg_act_e;
endpackage

// File: rtl/pps_sync_edge.sv
module pps_sync_edge #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_in,
   output logic rise
);
   logic [STAGES-1:0] chain_q;
   logic              prev_q;

   genvar g;
   generate
      for (g = 0; g < STAGES; g++) begin : g_stage
         if (g == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n)
               if (!rst_n) chain_q[0] <= 1'b0;
               else        chain_q[0] <= async_in;
         end else begin : g_rest
            always_ff @(posedge clk or negedge rst_n)
               if (!rst_n) chain_q[g] <= 1'b0;
               else        chain_q[g] <= chain_q[g-1];
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= chain_q[STAGES-1];

   assign rise = chain_q[STAGES-1] & ~prev_q;
endmodule

// File: rtl/pps_cfg_check.sv
module pps_cfg_check #(
   parameter int NSEG   = 4,
   parameter int LEN_W  = 12,
   localparam int SEG_W  = $clog2(NSEG),
   localparam int CNTS_W = $clog2(NSEG+1)
) (
   input  logic [NSEG*LEN_W-1:0] seg_len,
   input  logic [CNTS_W-1:0]     seg_count,
   input  logic                  loop_on,
   input  logic [SEG_W-1:0]      loop_first,
   input  logic [SEG_W-1:0]      loop_last,
   output logic                  bad
);
   logic [NSEG-1:0] empty_used;

   genvar g;
   generate
      for (g = 0; g < NSEG; g++) begin : g_seg
         assign empty_used[g] = (g < int'(seg_count)) &&
                                (seg_len[g*LEN_W +: LEN_W] == '0);
      end
   endgenerate

   logic count_bad, loop_bad;
   assign count_bad = (seg_count == '0) || (int'(seg_count) > NSEG);
   assign loop_bad  = loop_on && ((loop_first > loop_last) ||
                                  (int'(loop_last) >= int'(seg_count)));
   assign bad = count_bad || loop_bad || (|empty_used);
endmodule

// File: rtl/pps_loop_ctrl.sv
module pps_loop_ctrl
   import pps_pkg::*;
#(
   parameter int NSEG   = 4,
   parameter int CNT_W  = 8,
   localparam int SEG_W  = $clog2(NSEG),
   localparam int CNTS_W = $clog2(NSEG+1)
) (
   input  logic [SEG_W-1:0]  seg_cur,
   input  logic [CNT_W-1:0]  left_cur,
   input  logic [CNTS_W-1:0] seg_count,
   input  logic              loop_on,
   input  logic [SEG_W-1:0]  loop_first,
   input  logic [SEG_W-1:0]  loop_last,
   input  logic [CNT_W-1:0]  loop_reps,
   output seg_act_e          act,
   output logic [SEG_W-1:0]  seg_nxt,
   output logic [CNT_W-1:0]  left_nxt
);
   logic at_end, endless, jump_back;
   assign at_end    = loop_on && (seg_cur == loop_last);
   assign endless   = (loop_reps == '0);
   assign jump_back = at_end && (endless || (left_cur > CNT_W'(1)));

   always_comb begin
      act      = ACT_NEXT;
      seg_nxt  = seg_cur + SEG_W'(1);
      left_nxt = left_cur;
      if (jump_back) begin
         act     = ACT_LOOP;
         seg_nxt = loop_first;
         if (!endless) left_nxt = left_cur - CNT_W'(1);
      end else begin
         if (at_end) left_nxt = '0;
         if (int'(seg_cur) + 1 >= int'(seg_count)) act = ACT_FINISH;
      end
   end
endmodule

// File: rtl/pps_player.sv
module pps_player
   import pps_pkg::*;
#(
   parameter int NSEG        = 4,
   parameter int ADDR_W      = 16,
   parameter int LEN_W       = 12,
   parameter int CNT_W       = 8,
   parameter int SYNC_STAGES = 2,
   localparam int SEG_W  = $clog2(NSEG),
   localparam int CNTS_W = $clog2(NSEG+1)
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   en,
   input  logic                   cmd_start,
   input  logic                   aux_in,
   input  logic [NSEG*ADDR_W-1:0] seg_base,
   input  logic [NSEG*LEN_W-1:0]  seg_len,
   input  logic [CNTS_W-1:0]      seg_count,
   input  logic                   loop_on,
   input  logic [SEG_W-1:0]       loop_first,
   input  logic [SEG_W-1:0]       loop_last,
   input  logic [CNT_W-1:0]       loop_reps,
   output logic [ADDR_W-1:0]      rd_addr,
   output logic                   rd_valid,
   output logic [SEG_W-1:0]       seg_idx,
   output logic [CNT_W-1:0]       loops_left,
   output logic                   done,
   output logic                   cfg_err
);
   generate
      if (NSEG < 2 || NSEG > 4) begin : g_bad_nseg
         $error("pps_player: NSEG must lie in 2..4");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("pps_player: SYNC_STAGES must be at least 2");
      end
      if (LEN_W > ADDR_W) begin : g_bad_len
         $error("pps_player: LEN_W must not exceed ADDR_W");
      end
   endgenerate

   logic aux_rise;
   pps_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .async_in(aux_in), .rise(aux_rise)
   );

   pps_cfg_check #(.NSEG(NSEG), .LEN_W(LEN_W)) u_cfg (
      .seg_len(seg_len), .seg_count(seg_count), .loop_on(loop_on),
      .loop_first(loop_first), .loop_last(loop_last), .bad(cfg_err)
   );

   logic              busy_q, done_q;
   logic [SEG_W-1:0]  seg_q;
   logic [LEN_W-1:0]  off_q;
   logic [ADDR_W-1:0] addr_q;
   logic [CNT_W-1:0]  left_q;

   seg_act_e         act;
   logic [SEG_W-1:0] seg_nxt;
   logic [CNT_W-1:0] left_nxt;

   pps_loop_ctrl #(.NSEG(NSEG), .CNT_W(CNT_W)) u_loop (
      .seg_cur(seg_q), .left_cur(left_q), .seg_count(seg_count),
      .loop_on(loop_on), .loop_first(loop_first), .loop_last(loop_last),
      .loop_reps(loop_reps), .act(act), .seg_nxt(seg_nxt), .left_nxt(left_nxt)
   );

   logic [LEN_W-1:0]  cur_len;
   logic [ADDR_W-1:0] nxt_base;
   logic              last_word, go;

   assign cur_len   = seg_len[seg_q*LEN_W +: LEN_W];
   assign nxt_base  = seg_base[seg_nxt*ADDR_W +: ADDR_W];
   assign last_word = (off_q == cur_len - LEN_W'(1));
   assign go        = en && !busy_q && !cfg_err && (cmd_start || aux_rise);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         done_q <= 1'b0;
         seg_q  <= '0;
         off_q  <= '0;
         addr_q <= '0;
         left_q <= '0;
      end else if (!en) begin
         busy_q <= 1'b0;
         done_q <= 1'b0;
      end else if (go) begin
         busy_q <= 1'b1;
         done_q <= 1'b0;
         seg_q  <= '0;
         off_q  <= '0;
         addr_q <= seg_base[ADDR_W-1:0];
         left_q <= loop_reps;
      end else if (busy_q) begin
         if (!last_word) begin
            off_q  <= off_q + LEN_W'(1);
            addr_q <= addr_q + ADDR_W'(1);
         end else if (act == ACT_FINISH) begin
            busy_q <= 1'b0;
            done_q <= 1'b1;
            left_q <= left_nxt;
         end else begin
            seg_q  <= seg_nxt;
            off_q  <= '0;
            addr_q <= nxt_base;
            left_q <= left_nxt;
         end
      end
   end

   assign rd_addr    = addr_q;
   assign rd_valid   = busy_q;
   assign seg_idx    = seg_q;
   assign loops_left = left_q;
   assign done       = done_q;
endmodule

// File: rtl/pps_player_chk.sv
module pps_player_chk #(
   parameter int NSEG   = 4,
   parameter int ADDR_W = 16,
   parameter int CNT_W  = 8,
   localparam int SEG_W  = $clog2(NSEG),
   localparam int CNTS_W = $clog2(NSEG+1)
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic                   en,
   input logic [NSEG*ADDR_W-1:0] seg_base,
   input logic [CNTS_W-1:0]      seg_count,
   input logic [ADDR_W-1:0]      rd_addr,
   input logic                   rd_valid,
   input logic [SEG_W-1:0]       seg_idx,
   input logic [CNT_W-1:0]       loops_left,
   input logic                   done,
   input logic                   cfg_err
);
   // R2: a run opens on segment 0 at its base word
   a_r2_start_at_base: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rd_valid) |-> (seg_idx == '0) && (rd_addr == seg_base[ADDR_W-1:0]));

   // R1: the segment in play is always one of the used segments
   a_r1_seg_in_range: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |-> (int'(seg_idx) < int'(seg_count)));

   // R6: a finished run holds its last address
   a_r6_done_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (done && $past(done)) |-> (rd_addr == $past(rd_addr)));

   // R6: playing and finished never coexist
   a_r6_excl: assert property (@(posedge clk) disable iff (!rst_n)
      !(done && rd_valid));

   // R7: a bad table keeps an idle block idle
   a_r7_err_blocks: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_err && !rd_valid) |=> !rd_valid);

   // R9: disabled means idle on the next cycle
   a_r9_en_low_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> (!rd_valid && !done));

   // R4: within a run the pass count never rises
   a_r4_left_nonincr: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_valid && $past(rd_valid)) |-> (loops_left <= $past(loops_left)));
endmodule

bind pps_player pps_player_chk #(.NSEG(NSEG), .ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .en(en), .seg_base(seg_base), .seg_count(seg_count),
   .rd_addr(rd_addr), .rd_valid(rd_valid), .seg_idx(seg_idx),
   .loops_left(loops_left), .done(done), .cfg_err(cfg_err)
);

// File: tb/sim_pps_player.sv
module sim_pps_player;
   localparam int NSEG = 4, ADDR_W = 16, LEN_W = 12, CNT_W = 8;
   localparam int SEG_W = $clog2(NSEG), CNTS_W = $clog2(NSEG+1);
   localparam int MAXW = 1024;

   logic clk = 1'b0, rst_n = 1'b0, en = 1'b0, cmd_start = 1'b0, aux_in = 1'b0;
   logic [NSEG*ADDR_W-1:0] seg_base = '0;
   logic [NSEG*LEN_W-1:0]  seg_len  = '0;
   logic [CNTS_W-1:0]      seg_count = '0;
   logic                   loop_on = 1'b0;
   logic [SEG_W-1:0]       loop_first = '0, loop_last = '0;
   logic [CNT_W-1:0]       loop_reps = '0;
   logic [ADDR_W-1:0]      rd_addr;
   logic                   rd_valid, done, cfg_err;
   logic [SEG_W-1:0]       seg_idx;
   logic [CNT_W-1:0]       loops_left;

   always #4 clk = ~clk;

   pps_player #(.NSEG(NSEG), .ADDR_W(ADDR_W), .LEN_W(LEN_W), .CNT_W(CNT_W)) u0 (.*);

   int n_tests = 0, n_fail = 0;
   int mb[NSEG], ml[NSEG], mcnt, mlon, mlf, mll, mreps;
   int ea[MAXW], es[MAXW], el[MAXW], en_words;
   bit efinite;

   task automatic check(input bit ok, input string rq, input string what,
                        input longint act, input longint exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
      end
   endtask

   task automatic tick; @(posedge clk); #1; endtask

   task automatic load_cfg;
      for (int i = 0; i < NSEG; i++) begin
         seg_base[i*ADDR_W +: ADDR_W] = ADDR_W'(mb[i]);
         seg_len[i*LEN_W +: LEN_W]    = LEN_W'(ml[i]);
      end
      seg_count  = CNTS_W'(mcnt);
      loop_on    = mlon[0];
      loop_first = SEG_W'(mlf);
      loop_last  = SEG_W'(mll);
      loop_reps  = CNT_W'(mreps);
   endtask

   // reference trace from the requirements
   task automatic build_expect(input int cap);
      int s, left;
      bit stop;
      s = 0; left = mreps; en_words = 0; efinite = 0; stop = 0;
      while (!stop && en_words < cap) begin
         for (int o = 0; o < ml[s] && en_words < cap; o++) begin
            ea[en_words] = mb[s] + o; es[en_words] = s; el[en_words] = left;
            en_words++;
         end
         if (mlon != 0 && s == mll && (mreps == 0 || left > 1)) begin
            s = mlf;
            if (mreps != 0) left--;
         end else begin
            if (mlon != 0 && s == mll) left = 0;
            s++;
            if (s >= mcnt) begin stop = 1; efinite = (en_words <= cap); end
         end
      end
   endtask

   // start by command, compare trace; poke >= 0 pulses cmd_start mid-run
   task automatic play(input string rq, input int cap, input int poke);
      int errs, fi;
      longint fa, fe;
      build_expect(cap);
      cmd_start = 1'b1; tick; cmd_start = 1'b0;
      errs = 0; fi = -1; fa = 0; fe = 0;
      for (int i = 0; i < en_words; i++) begin
         if (!rd_valid || rd_addr != ADDR_W'(ea[i]) || seg_idx != SEG_W'(es[i]) ||
             loops_left != CNT_W'(el[i])) begin
            if (fi < 0) begin fi = i; fa = rd_addr; fe = ea[i]; end
            errs++;
         end
         cmd_start = (i == poke);
         tick;
      end
      cmd_start = 1'b0;
      check(errs == 0, rq, $sformatf("trace word %0d addr", fi), fa, fe);
      if (efinite) begin
         check(!rd_valid && done && rd_addr == ADDR_W'(ea[en_words-1]), "R6",
               "done and last address", rd_addr, ea[en_words-1]);
         repeat (5) tick;
         check(done && rd_addr == ADDR_W'(ea[en_words-1]), "R6",
               "address held after done", rd_addr, ea[en_words-1]);
      end
   endtask

   task automatic t_reset;
      check(!rd_valid && !done, "R10", "idle after reset", {rd_valid, done}, 0);
      check(rd_addr == 0 && seg_idx == 0 && loops_left == 0, "R10", "zero outputs",
            rd_addr, 0);
   endtask

   task automatic t_linear;
      mb = '{100, 200, 300, 400}; ml = '{3, 1, 4, 0}; mcnt = 3;
      mlon = 0; mlf = 0; mll = 0; mreps = 0;
      load_cfg; #1;
      check(cfg_err == 0, "R7", "unused empty segment is legal", cfg_err, 0);
      play("R1 R2", 64, -1);
   endtask

   task automatic t_counted;
      mb = '{100, 200, 300, 400}; ml = '{2, 3, 1, 2}; mcnt = 4;
      mlon = 1; mlf = 1; mll = 2; mreps = 3;
      load_cfg; #1;
      play("R4 R8", 128, 6);
      check(loops_left == 0, "R4", "pass count after exit", loops_left, 0);
      // single-segment loop on the final segment
      mb = '{10, 20, 30, 40}; ml = '{1, 2, 1, 1}; mcnt = 2;
      mlon = 1; mlf = 1; mll = 1; mreps = 2;
      load_cfg; #1;
      play("R4", 64, 1);
   endtask

   task automatic t_endless;
      mb = '{500, 600, 700, 800}; ml = '{2, 1, 1, 1}; mcnt = 3;
      mlon = 1; mlf = 0; mll = 1; mreps = 0;
      load_cfg; #1;
      play("R5", 90, 40);
      check(rd_valid && !done, "R5", "endless loop still running", rd_valid, 1);
      en = 1'b0; tick;
      check(!rd_valid && !done, "R9", "en low stops playback", rd_valid, 0);
      cmd_start = 1'b1; tick; cmd_start = 1'b0; tick;
      check(!rd_valid, "R9", "start ignored while disabled", rd_valid, 0);
      en = 1'b1; tick;
   endtask

   task automatic t_invalid;
      mb = '{1, 2, 3, 4}; ml = '{1, 1, 1, 1}; mcnt = 4;
      mlon = 1; mlf = 2; mll = 1; mreps = 2;
      load_cfg; #1;
      check(cfg_err == 1, "R7", "loop first after last", cfg_err, 1);
      cmd_start = 1'b1; tick; cmd_start = 1'b0; tick;
      check(!rd_valid, "R7", "start blocked by bad table", rd_valid, 0);
      mlf = 0; mll = 3; mcnt = 3; load_cfg; #1;
      check(cfg_err == 1, "R7", "loop end beyond count", cfg_err, 1);
      mlon = 0; ml = '{1, 0, 1, 1}; load_cfg; #1;
      check(cfg_err == 1, "R7", "empty used segment", cfg_err, 1);
      ml = '{1, 1, 1, 1}; mcnt = 0; load_cfg; #1;
      check(cfg_err == 1, "R7", "zero segment count", cfg_err, 1);
      mcnt = 5; load_cfg; #1;
      check(cfg_err == 1, "R7", "segment count above four", cfg_err, 1);
   endtask

   task automatic t_aux;
      mb = '{900, 950, 0, 0}; ml = '{2, 2, 1, 1}; mcnt = 2;
      mlon = 0; mlf = 0; mll = 0; mreps = 0;
      load_cfg; tick;
      aux_in = 1'b1;
      tick; tick;
      check(!rd_valid, "R3", "not yet started after two edges", rd_valid, 0);
      tick;
      check(rd_valid && rd_addr == 900, "R3", "started on third edge", rd_addr, 900);
      repeat (10) tick;
      check(done && !rd_valid, "R3", "held level gives no restart", rd_valid, 0);
      aux_in = 1'b0; repeat (3) tick;
      check(!rd_valid, "R3", "falling edge gives no start", rd_valid, 0);
      aux_in = 1'b1; repeat (3) tick;
      check(rd_valid && rd_addr == 900 && !done, "R3", "second edge restarts",
            rd_addr, 900);
      aux_in = 1'b0; repeat (6) tick;
   endtask

   initial begin
      #(8 * 150000);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests + 1, n_fail);
      $finish;
   end

   initial begin
      repeat (3) tick;
      t_reset;
      rst_n = 1'b1; en = 1'b1; tick;
      t_linear;
      t_counted;
      t_endless;
      t_aux;
      t_invalid;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule